// File: doc/BRIEF.md
# I2C Repeated-Start Sequencer with Arbitration Check

This block produces an I2C Repeated Start on a bus that the local master already owns, with SCL held low after the last bit of a byte. A level enable from the controller starts the sequence. The block then releases SDA and, after one baud interval, releases SCL. It waits out any clock stretching and checks the SDA level once SCL reads high. If SDA is still high, it times a high-phase window. After that window it pulls SDA low, times one more interval, and then pulls SCL low.

The sequence watches for two ways of losing the bus to another master. In the first, SDA is already low when SCL has risen. In the second, SCL is pulled low during the high-phase window before the block has asserted SDA. On either collision the block frees both lines, raises a collision flag and returns to idle. On success it keeps both lines low, so the bus stays owned for the address byte that follows, and it raises an interrupt flag. In both cases it gives a one-cycle pulse that clears the controller's enable. A clear input resets both flags.

Each timed interval is `reload + 1` clock cycles. It is taken from a down-counter that is loaded with the reload value and expires when it reaches zero.

Top module: `i2c_rstart_gen`

## Requirements
- R1: During and right after a synchronous active-low reset, both line drives are released (0), and the enable-clear pulse, the collision flag and the interrupt flag are all 0.
- R2: When `rs_en` is 1 in idle, the block drives SCL low (`scl_drv_low`=1) and releases SDA for `reload`+1 cycles, starting the cycle after the edge that sampled `rs_en`.
- R3: It then releases both lines and stays in that state while `scl_in` reads 0, so clock stretching lengthens the phase cycle for cycle.
- R4: In the first cycle in which `scl_in` reads 1, a 0 on `sda_in` is a collision. From the next cycle both lines are released, `coll_flag` is 1, `en_clr` pulses and `irq_flag` stays 0.
- R5: If `sda_in` reads 1 at that point, both lines stay released for a high-phase window of `reload`+1 cycles. A fall of `sda_in` inside this window is not a collision.
- R6: `scl_in` reading 0 in any cycle of the high-phase window is a collision, with the outcome given in R4, starting the cycle after.
- R7: After the window the block drives SDA low with SCL released for `reload`+1 cycles, whatever level `scl_in` has.
- R8: On completion both lines are driven low and stay driven low in idle, `irq_flag` becomes 1 and `en_clr` is 1 for exactly one cycle.
- R9: A 1 on `flag_clr` clears `coll_flag` and `irq_flag` on the next edge and leaves both line drives unchanged.
- R10: The cycle in which `en_clr` is 1 does not start a new sequence, even if `rs_en` is still 1 during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rs_en | input | 1 | Repeated Start request, level, held until cleared through `en_clr` |
| sda_in | input | 1 | Synchronized SDA level |
| scl_in | input | 1 | Synchronized SCL level |
| reload | input | RELOAD_W | Baud interval reload value; each interval is reload+1 cycles |
| flag_clr | input | 1 | Clears the collision and interrupt flags |
| sda_drv_low | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_drv_low | output | 1 | 1 pulls SCL low, 0 releases it |
| en_clr | output | 1 | One-cycle pulse that clears the request enable |
| coll_flag | output | 1 | Sticky bus collision flag |
| irq_flag | output | 1 | Sticky completion flag |

## Verification
The bench builds the block with `RELOAD_W` = 3, which makes every reload value from 0 to 7 reachable in a full sweep. For each reload value it runs a clean sequence and a sequence with a clock stretch of two cycles. Against both it runs the collision where SDA is held low, and it pulls SCL low at every offset of the high-phase window. It pulls SDA low at every offset of the same window and SCL low at every offset of the final phase. An open-drain bus model combines the block's drives with the bench's, and the expected drives and flags for each cycle are computed from the phase boundaries that the reload value and the stretch give.

// File: rtl/rsg_pkg.sv
// Shared types for the repeated-start sequencer.
// Assumes: used only by the rsg_* modules and i2c_rstart_gen.
package rsg_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        RS_IDLE    = 3'd0,
        RS_REL_SDA = 3'd1,
        RS_SCL_REL = 3'd2,
        RS_HI_CHK  = 3'd3,
        RS_SDA_LOW = 3'd4
    } rs_state_t;

endpackage

// File: rtl/rsg_baud_cnt.sv
// Baud interval down-counter. The counter is loaded with the reload value
// and counts down to zero; tick is high while the count is zero.
// Assumes: load is pulsed on the edge that enters a timed phase, so a phase
// lasts reload+1 cycles.
module rsg_baud_cnt #(
    parameter int RELOAD_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [RELOAD_W-1:0] reload,
    output logic                tick
);

    localparam logic [RELOAD_W-1:0] CNT_ZERO = '0;

    logic [RELOAD_W-1:0] cnt_q;

    // Load on request, otherwise count down and stop at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_ZERO;
        end else if (load) begin
            cnt_q <= reload;
        end else if (cnt_q != CNT_ZERO) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry indication
    always_comb tick = (cnt_q == CNT_ZERO);

endmodule

// File: rtl/rsg_seq.sv
// Repeated-start phase sequencer with collision detection.
// Produces the line drives, the counter load, the enable-clear pulse and the
// one-cycle set strobes for the collision and completion flags.
// Assumes: sda_in/scl_in are already synchronized; on entry SCL is owned.
module rsg_seq
    import rsg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rs_en,
    input  logic sda_in,
    input  logic scl_in,
    input  logic tick,
    output logic load,
    output logic sda_drv_low,
    output logic scl_drv_low,
    output logic en_clr,
    output logic coll_set,
    output logic done_set
);

    rs_state_t state_q, state_d;
    logic      hold_q;
    logic      en_clr_q;

    // Next-phase decision and collision/completion strobes
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        coll_set = 1'b0;
        done_set = 1'b0;
        unique case (state_q)
            RS_IDLE: begin
                if (rs_en && !en_clr_q) begin
                    state_d = RS_REL_SDA;
                    load    = 1'b1;
                end
            end
            RS_REL_SDA: begin
                if (tick) state_d = RS_SCL_REL;
            end
            RS_SCL_REL: begin
                if (scl_in) begin
                    if (!sda_in) begin
                        coll_set = 1'b1;
                        state_d  = RS_IDLE;
                    end else begin
                        load    = 1'b1;
                        state_d = RS_HI_CHK;
                    end
                end
            end
            RS_HI_CHK: begin
                if (!scl_in) begin
                    coll_set = 1'b1;
                    state_d  = RS_IDLE;
                end else if (tick) begin
                    load    = 1'b1;
                    state_d = RS_SDA_LOW;
                end
            end
            RS_SDA_LOW: begin
                if (tick) begin
                    done_set = 1'b1;
                    state_d  = RS_IDLE;
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // Phase, bus-hold and enable-clear registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RS_IDLE;
            hold_q   <= 1'b0;
            en_clr_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            en_clr_q <= coll_set | done_set;
            if (done_set)      hold_q <= 1'b1;
            else if (coll_set) hold_q <= 1'b0;
        end
    end

    // Line drives per phase
    always_comb begin
        sda_drv_low = 1'b0;
        scl_drv_low = 1'b0;
        unique case (state_q)
            RS_IDLE: begin
                sda_drv_low = hold_q;
                scl_drv_low = hold_q;
            end
            RS_REL_SDA: scl_drv_low = 1'b1;
            RS_SDA_LOW: sda_drv_low = 1'b1;
            default: ;
        endcase
    end

    assign en_clr = en_clr_q;

    AST_SDA_FALL_WITH_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drv_low) |-> !scl_drv_low); // R7
    AST_SCL_FREED_AFTER_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_drv_low) |-> !sda_drv_low); // R3
    AST_EN_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> !en_clr); // R10
    AST_NO_START_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> (sda_drv_low == scl_drv_low)); // R10

endmodule

// File: rtl/rsg_flags.sv
// Sticky collision and completion flags with a common clear.
// Assumes: set strobes are single-cycle; a set wins over a clear.
module rsg_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic coll_set,
    input  logic done_set,
    input  logic flag_clr,
    output logic coll_flag,
    output logic irq_flag
);

    // Flag registers: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coll_flag <= 1'b0;
            irq_flag  <= 1'b0;
        end else begin
            if (coll_set)      coll_flag <= 1'b1;
            else if (flag_clr) coll_flag <= 1'b0;
            if (done_set)      irq_flag  <= 1'b1;
            else if (flag_clr) irq_flag  <= 1'b0;
        end
    end

    AST_FLAG_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !coll_set && !done_set) |=> (!coll_flag && !irq_flag)); // R9

endmodule

// File: rtl/i2c_rstart_gen.sv
// Top of the I2C repeated-start generator: sequencer, baud counter and flags.
// Assumes: synchronized line inputs; rs_en is held until en_clr is seen.
module i2c_rstart_gen #(
    parameter int RELOAD_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rs_en,
    input  logic                sda_in,
    input  logic                scl_in,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                flag_clr,
    output logic                sda_drv_low,
    output logic                scl_drv_low,
    output logic                en_clr,
    output logic                coll_flag,
    output logic                irq_flag
);

    logic load;
    logic tick;
    logic coll_set;
    logic done_set;

    rsg_baud_cnt #(.RELOAD_W(RELOAD_W)) baud_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .reload (reload),
        .tick   (tick)
    );

    rsg_seq seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rs_en       (rs_en),
        .sda_in      (sda_in),
        .scl_in      (scl_in),
        .tick        (tick),
        .load        (load),
        .sda_drv_low (sda_drv_low),
        .scl_drv_low (scl_drv_low),
        .en_clr      (en_clr),
        .coll_set    (coll_set),
        .done_set    (done_set)
    );

    rsg_flags flags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .coll_set  (coll_set),
        .done_set  (done_set),
        .flag_clr  (flag_clr),
        .coll_flag (coll_flag),
        .irq_flag  (irq_flag)
    );

    AST_COLL_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll_flag) |-> (!sda_drv_low && !scl_drv_low && en_clr)); // R4
    AST_DONE_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> (sda_drv_low && scl_drv_low && en_clr)); // R8
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(coll_flag) && $rose(irq_flag))); // R4

endmodule

// File: tb/i2c_rstart_gen_tb_top.sv
module i2c_rstart_gen_tb_top;

    localparam int RW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rs_en = 1'b0;
    logic [RW-1:0] reload = '0;
    logic          flag_clr = 1'b0;
    logic          ext_sda_low = 1'b0;
    logic          ext_scl_low = 1'b0;
    logic          sda_drv_low, scl_drv_low, en_clr, coll_flag, irq_flag;
    logic          sda_in, scl_in;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    // open-drain bus model
    assign sda_in = !(sda_drv_low || ext_sda_low);
    assign scl_in = !(scl_drv_low || ext_scl_low);

    i2c_rstart_gen #(.RELOAD_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n), .rs_en(rs_en), .sda_in(sda_in), .scl_in(scl_in),
        .reload(reload), .flag_clr(flag_clr), .sda_drv_low(sda_drv_low),
        .scl_drv_low(scl_drv_low), .en_clr(en_clr), .coll_flag(coll_flag),
        .irq_flag(irq_flag)
    );

    task automatic check(input string req, input logic [4:0] exp_v);
        logic [4:0] act;
        act = {sda_drv_low, scl_drv_low, en_clr, coll_flag, irq_flag};
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s t=%0t {sda,scl,clr,coll,irq} actual=%b expected=%b",
                     req, $time, act, exp_v);
        end
    endtask

    // mode: 0 clean, 1 SDA held low (R4), 2 SCL low in window (R6),
    //       3 SDA low in window (R5), 4 SCL low in final phase (R7)
    task automatic run_case(input int r, input int s, input int mode, input int k);
        int coll_c, dn, fin;
        logic [4:0] e;
        string tag;
        dn = 3*r + 4 + s;
        coll_c = (mode == 1) ? r + 2 + s : (mode == 2) ? r + 3 + s + k : -1;
        fin = (coll_c >= 0) ? coll_c : dn;
        @(negedge clk);
        reload = RW'(r);
        rs_en = 1'b1;
        ext_scl_low = (s > 0);
        ext_sda_low = (mode == 1);
        for (int c = 0; c <= fin; c++) begin
            @(negedge clk);
            if (coll_c >= 0 && c >= coll_c) begin
                e = 5'b00110; tag = (mode == 1) ? "R4" : "R6";
            end else if (c >= dn) begin
                e = 5'b11101; tag = "R8";
            end else if (c <= r) begin
                e = 5'b01000; tag = "R2";
            end else if (c <= r + 1 + s) begin
                e = 5'b00000; tag = "R3";
            end else if (c <= 2*r + 2 + s) begin
                e = 5'b00000; tag = "R5";
            end else begin
                e = 5'b10000; tag = "R7";
            end
            check(tag, e);
            if (c == r + 1 + s) ext_scl_low = 1'b0;
            if (mode == 2 && c == r + 2 + s + k) ext_scl_low = 1'b1;
            if (mode == 3 && c == r + 2 + s + k) ext_sda_low = 1'b1;
            if (mode == 4 && c == 2*r + 3 + s + k) ext_scl_low = 1'b1;
        end
        // enable register clears on the edge that sees en_clr
        @(posedge clk);
        rs_en <= 1'b0;
        @(negedge clk);
        e = (coll_c >= 0) ? 5'b00010 : 5'b11001;
        check("R10", e);
        ext_scl_low = 1'b0;
        ext_sda_low = 1'b0;
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        e = (coll_c >= 0) ? 5'b00000 : 5'b11000;
        check("R9", e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 5'b00000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 5'b00000);
        for (int r = 0; r < (1 << RW); r++) begin
            for (int si = 0; si < 2; si++) begin
                run_case(r, si * 2, 0, 0);
                run_case(r, si * 2, 1, 0);
                for (int k = 0; k <= r; k++) begin
                    run_case(r, si * 2, 2, k);
                    run_case(r, si * 2, 3, k);
                    run_case(r, si * 2, 4, k);
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule